// File: doc/BRIEF.md
# Reconfigurable Single-Bit Macrocell Storage Element

This block is the one-bit storage point of a programmable-logic macrocell. Static configuration inputs turn it into an edge-triggered data register, an edge-triggered toggle register or a level-sensitive transparent latch. An exclusive-OR stage in front of the storage input, fed back from the stored value, lets the two register types also behave like J-K or set/reset flip-flops. Both input terms can be inverted.

The timing input is chosen from a set of shared block clocks by a select field, or from a per-cell product-term clock. A polarity bit picks the active edge, or for the latch the active level. Two block-wide terms force the bit asynchronously to 0 or 1. An active-low power-on input loads a configured power-up value. The logic array that produces the terms lies outside this block, so every term arrives as a plain wire.

Top module: `mcell_store`

## Requirements
- R1: While `por_n` is 0, `q` equals `cfg_pu_preset` (0 = power-up reset, 1 = power-up preset), whatever `blk_rst` and `blk_set` are.
- R2: With `cfg_kind` = 2'b00 (2'b11 acts the same) and `cfg_emul` = 0, `q` takes the data term on each active edge of the effective clock and holds at every other time.
- R3: With `cfg_kind` = 2'b01 and `cfg_emul` = 0, `q` inverts on an active edge when the data term is 1, holds on an edge when it is 0, and holds between edges.
- R4: With `cfg_kind` = 2'b10, `q` follows the data term while the effective clock is at its active level and holds while it is inactive. `term_b` and `cfg_emul` have no effect in this mode.
- R5: With `cfg_kind` = 2'b01 and `cfg_emul` = 1, `term_a` acts as J and `term_b` acts as K. On an active edge, J=K=0 holds, J=1 K=0 sets, J=0 K=1 clears, and J=K=1 toggles.
- R6: With `cfg_kind` = 2'b00 and `cfg_emul` = 1, `term_a` acts as S and `term_b` acts as R. On an active edge, S=R=0 holds, S=1 R=0 sets, S=0 R=1 clears, and S=R=1 toggles.
- R7: `cfg_in_inv` = 1 inverts both `term_a` and `term_b` before they are used, in every storage type.
- R8: The effective clock source is `blk_clk[cfg_clk_sel]` when `cfg_use_pt` = 0 and `pt_clk` when `cfg_use_pt` = 1. Clocks that are not selected have no effect on `q`.
- R9: `cfg_clk_inv` = 0 makes the rising edge (latch: high level) active. `cfg_clk_inv` = 1 makes the falling edge (latch: low level) active.
- R10: With `por_n` = 1, `blk_rst` = 1 forces `q` to 0 at once and overrides `blk_set`. `blk_set` = 1 alone forces `q` to 1 at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| por_n | input | 1 | Active-low power-on initialisation |
| blk_clk | input | NUM_CLK (4) | Shared block clocks |
| pt_clk | input | 1 | Per-cell product-term clock |
| cfg_kind | input | 2 | Storage type: 00 data reg, 01 toggle reg, 10 latch |
| cfg_emul | input | 1 | Enables J-K / set-reset emulation through the feedback XOR |
| cfg_in_inv | input | 1 | Inverts both input terms |
| cfg_clk_inv | input | 1 | Makes the falling edge or low level active |
| cfg_use_pt | input | 1 | Selects the product-term clock instead of a block clock |
| cfg_clk_sel | input | SEL_W (2) | Block clock index |
| cfg_pu_preset | input | 1 | Power-up value of `q` |
| term_a | input | 1 | Data / toggle / J / S term |
| term_b | input | 1 | K / R term |
| blk_rst | input | 1 | Block-wide asynchronous reset term |
| blk_set | input | 1 | Block-wide asynchronous preset term |
| q | output | 1 | Stored bit |

## Verification
The assertions are sampled on the inactive edge of the effective clock, using values from just before that edge. They therefore assume that configuration inputs change only while `por_n` is low, and that an asynchronous term or data term never changes in the same instant as that edge. The stimulus meets this by changing exactly one input bit per step. Each full configuration sweep starts with a power-on pulse, during which the new settings are applied before any clock or data activity.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [1:0] {
    KIND_DREG  = 2'b00,
    KIND_TREG  = 2'b01,
    KIND_LATCH = 2'b10,
    KIND_DALT  = 2'b11
  } store_kind_e;
endpackage

// File: rtl/mcell_clk_pick.sv
module mcell_clk_pick #(
  parameter int NUM_CLK = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_CLK-1:0] blk_clk,
  input  logic               pt_clk,
  input  logic               use_pt,
  input  logic [SEL_W-1:0]   sel,
  input  logic               inv,
  output logic               eff_clk
);
  logic src;

  always_comb begin
    src = 1'b0;
    for (int i = 0; i < NUM_CLK; i++) begin
      if (sel == SEL_W'(i)) src = blk_clk[i];
    end
    if (use_pt) src = pt_clk;
  end

  assign eff_clk = src ^ inv;
endmodule

// File: rtl/mcell_xor_in.sv
module mcell_xor_in
  import mcell_pkg::*;
(
  input  store_kind_e kind,
  input  logic        emul,
  input  logic        in_inv,
  input  logic        term_a,
  input  logic        term_b,
  input  logic        q_fb,
  output logic        reg_d,
  output logic        lat_d
);
  logic ai, bi, fb_term, base, xin;

  assign ai      = term_a ^ in_inv;
  assign bi      = term_b ^ in_inv;
  // term that flips the stored bit: first term when clear, second when set
  assign fb_term = (ai & ~q_fb) | (bi & q_fb);

  always_comb begin
    unique case (kind)
      KIND_TREG: begin
        base = q_fb;
        xin  = emul ? fb_term : ai;
      end
      default: begin
        base = emul ? q_fb : 1'b0;
        xin  = emul ? fb_term : ai;
      end
    endcase
  end

  assign reg_d = base ^ xin;
  assign lat_d = ai;
endmodule

// File: rtl/mcell_init.sv
module mcell_init (
  input  logic por_n,
  input  logic pu_preset,
  input  logic ar,
  input  logic ap,
  output logic clr,
  output logic set
);
  assign clr = (~por_n & ~pu_preset) | (por_n & ar);
  assign set = (~por_n &  pu_preset) | (por_n & ap & ~ar);
endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
#(
  parameter  int NUM_CLK = 4,
  localparam int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               por_n,
  input  logic [NUM_CLK-1:0] blk_clk,
  input  logic               pt_clk,
  input  logic [1:0]         cfg_kind,
  input  logic               cfg_emul,
  input  logic               cfg_in_inv,
  input  logic               cfg_clk_inv,
  input  logic               cfg_use_pt,
  input  logic [SEL_W-1:0]   cfg_clk_sel,
  input  logic               cfg_pu_preset,
  input  logic               term_a,
  input  logic               term_b,
  input  logic               blk_rst,
  input  logic               blk_set,
  output logic               q
);
  store_kind_e kind;
  logic eff_clk, clr, set, reg_d, lat_d, reg_q, lat_q;

  assign kind = store_kind_e'(cfg_kind);

  mcell_clk_pick #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_clk (
    .blk_clk (blk_clk),
    .pt_clk  (pt_clk),
    .use_pt  (cfg_use_pt),
    .sel     (cfg_clk_sel),
    .inv     (cfg_clk_inv),
    .eff_clk (eff_clk)
  );

  mcell_init u_init (
    .por_n     (por_n),
    .pu_preset (cfg_pu_preset),
    .ar        (blk_rst),
    .ap        (blk_set),
    .clr       (clr),
    .set       (set)
  );

  mcell_xor_in u_xin (
    .kind   (kind),
    .emul   (cfg_emul),
    .in_inv (cfg_in_inv),
    .term_a (term_a),
    .term_b (term_b),
    .q_fb   (reg_q),
    .reg_d  (reg_d),
    .lat_d  (lat_d)
  );

  always_ff @(posedge eff_clk or posedge clr or posedge set) begin
    if (clr)      reg_q <= 1'b0;
    else if (set) reg_q <= 1'b1;
    else          reg_q <= reg_d;
  end

  always_latch begin
    if (clr)          lat_q <= 1'b0;
    else if (set)     lat_q <= 1'b1;
    else if (eff_clk) lat_q <= lat_d;
  end

  assign q = (kind == KIND_LATCH) ? lat_q : reg_q;
endmodule

// File: rtl/mcell_store_chk.sv
module mcell_store_chk (
  input logic       eff_clk,
  input logic       por_n,
  input logic       cfg_pu_preset,
  input logic [1:0] cfg_kind,
  input logic       cfg_in_inv,
  input logic       term_a,
  input logic       blk_rst,
  input logic       blk_set,
  input logic       q
);
  // R1: power-on value
  a_r1_por_value: assert property (@(negedge eff_clk)
    !por_n |-> (q == cfg_pu_preset));

  // R10: reset term dominates
  a_r10_rst_clears: assert property (@(negedge eff_clk) disable iff (!por_n)
    blk_rst |-> (q == 1'b0));

  // R10: preset term alone sets
  a_r10_set_presets: assert property (@(negedge eff_clk) disable iff (!por_n)
    (blk_set && !blk_rst) |-> (q == 1'b1));

  // R4: transparent latch shows the input until the enable leaves its active level
  a_r4_latch_follows: assert property (@(negedge eff_clk)
    disable iff (!por_n || blk_rst || blk_set)
    (cfg_kind == 2'b10) |-> (q == (term_a ^ cfg_in_inv)));
endmodule

bind mcell_store mcell_store_chk u_chk (
  .eff_clk       (eff_clk),
  .por_n         (por_n),
  .cfg_pu_preset (cfg_pu_preset),
  .cfg_kind      (cfg_kind),
  .cfg_in_inv    (cfg_in_inv),
  .term_a        (term_a),
  .blk_rst       (blk_rst),
  .blk_set       (blk_set),
  .q             (q)
);

// File: tb/mcell_store_test.sv
module mcell_store_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       por_n;
  logic [3:0] blk;
  logic       pt, emul, iinv, cinv, upt, pre, a, b, rst, setb;
  logic [1:0] kind, sel;
  logic       q;

  int  total = 0;
  int  fails = 0;
  bit  m_q, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcell_store uut (
    .por_n(por_n), .blk_clk(blk), .pt_clk(pt), .cfg_kind(kind), .cfg_emul(emul),
    .cfg_in_inv(iinv), .cfg_clk_inv(cinv), .cfg_use_pt(upt), .cfg_clk_sel(sel),
    .cfg_pu_preset(pre), .term_a(a), .term_b(b), .blk_rst(rst), .blk_set(setb), .q(q)
  );

  function automatic bit eff_now();
    bit s;
    s = upt ? pt : blk[sel];
    return cinv ? !s : s;
  endfunction

  // behavioural reference, re-evaluated after every single-bit input change
  task automatic model();
    bit e, ai, bi;
    e  = eff_now();
    ai = a ^ iinv;
    bi = b ^ iinv;
    if (!por_n)     m_q = pre;
    else if (rst)   m_q = 1'b0;
    else if (setb)  m_q = 1'b1;
    else if (kind == 2'b10) begin
      if (e) m_q = ai;
    end else if (e && !m_prev) begin
      if (emul)               m_q = m_q ? !bi : ai;
      else if (kind == 2'b01) m_q = m_q ? !ai : ai;
      else                    m_q = ai;
    end
    m_prev = e;
  endtask

  task automatic tick(input string tag);
    model();
    @(posedge clk);
    total++;
    if (q !== m_q) begin
      fails++;
      $display("FAIL %s q=%b expected=%b at %0t", tag, q, m_q, $time);
    end
    @(negedge clk);
  endtask

  task automatic lit(input string tag, input bit v);
    total++;
    if (q !== v) begin
      fails++;
      $display("FAIL %s literal q=%b expected=%b", tag, q, v);
    end
  endtask

  task automatic tog_src(input string tag);
    if (upt) pt = ~pt; else blk[sel] = ~blk[sel];
    tick(tag);
  endtask

  task automatic active_edge(input string tag);
    if (eff_now()) tog_src(tag);
    tog_src(tag);
  endtask

  task automatic setup(input logic [1:0] k, input bit em, input bit ii, input bit ci,
                       input bit up, input logic [1:0] s, input bit p);
    por_n = 1'b0; tick("R1");
    kind = k; emul = em; iinv = ii; cinv = ci; upt = up; sel = s; pre = p;
    blk = '0; pt = 1'b0; a = 1'b0; b = 1'b0; rst = 1'b0; setb = 1'b0;
    tick("R1");
    lit("R1", p);
    por_n = 1'b1; tick("R1");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; blk = '0; pt = 1'b0; kind = 2'b00; emul = 1'b0; iinv = 1'b0;
    cinv = 1'b0; upt = 1'b0; sel = 2'b00; pre = 1'b0; a = 1'b0; b = 1'b0;
    rst = 1'b0; setb = 1'b0; m_q = 1'b0; m_prev = 1'b0;
    @(negedge clk);
    tick("R1");
    lit("R1", 1'b0);
    rst = 1'b1; setb = 1'b1; pre = 1'b1; tick("R1");  // por dominates async terms
    lit("R1", 1'b1);
    rst = 1'b0; setb = 1'b0; tick("R1");

    // R2 data register
    setup(2'b00, 0, 0, 0, 0, 2'b00, 1);
    a = 1'b0; tick("R2"); lit("R2", 1'b1);
    active_edge("R2"); lit("R2", 1'b0);
    a = 1'b1; tick("R2"); lit("R2", 1'b0);
    tog_src("R2"); lit("R2", 1'b0);
    active_edge("R2"); lit("R2", 1'b1);
    setup(2'b11, 0, 0, 0, 0, 2'b01, 0);
    a = 1'b1; active_edge("R2"); lit("R2", 1'b1);

    // R3 toggle register
    setup(2'b01, 0, 0, 0, 0, 2'b10, 0);
    a = 1'b1; active_edge("R3"); lit("R3", 1'b1);
    active_edge("R3"); lit("R3", 1'b0);
    active_edge("R3"); a = 1'b0; tick("R3");
    active_edge("R3"); lit("R3", 1'b1);

    // R4 latch
    setup(2'b10, 0, 0, 0, 0, 2'b00, 0);
    a = 1'b1; tick("R4"); lit("R4", 1'b0);
    tog_src("R4"); lit("R4", 1'b1);
    a = 1'b0; tick("R4"); lit("R4", 1'b0);
    a = 1'b1; tick("R4");
    tog_src("R4"); a = 1'b0; tick("R4"); lit("R4", 1'b1);
    b = 1'b1; tick("R4"); emul = 1'b1; tick("R4"); lit("R4", 1'b1);

    // R5 J-K
    setup(2'b01, 1, 0, 0, 0, 2'b11, 0);
    a = 1'b1; b = 1'b0; active_edge("R5"); lit("R5", 1'b1);
    a = 1'b0; active_edge("R5"); lit("R5", 1'b1);
    b = 1'b1; active_edge("R5"); lit("R5", 1'b0);
    a = 1'b1; active_edge("R5"); lit("R5", 1'b1);
    active_edge("R5"); lit("R5", 1'b0);

    // R6 S-R
    setup(2'b00, 1, 0, 0, 0, 2'b00, 0);
    a = 1'b1; active_edge("R6"); lit("R6", 1'b1);
    a = 1'b0; active_edge("R6"); lit("R6", 1'b1);
    b = 1'b1; active_edge("R6"); lit("R6", 1'b0);
    a = 1'b1; active_edge("R6"); lit("R6", 1'b1);

    // R7 input inversion
    setup(2'b00, 0, 1, 0, 0, 2'b00, 1);
    a = 1'b1; active_edge("R7"); lit("R7", 1'b0);
    a = 1'b0; active_edge("R7"); lit("R7", 1'b1);

    // R8 clock source choice
    setup(2'b00, 0, 0, 0, 0, 2'b10, 0);
    a = 1'b1;
    blk[0] = 1'b1; tick("R8"); pt = 1'b1; tick("R8"); blk[3] = 1'b1; tick("R8");
    lit("R8", 1'b0);
    blk[2] = 1'b1; tick("R8"); lit("R8", 1'b1);
    setup(2'b00, 0, 0, 0, 1, 2'b00, 0);
    a = 1'b1; blk = 4'hF; tick("R8"); lit("R8", 1'b0);
    pt = 1'b1; tick("R8"); lit("R8", 1'b1);

    // R9 clock polarity
    setup(2'b00, 0, 0, 1, 0, 2'b01, 0);
    a = 1'b1; blk[1] = 1'b1; tick("R9"); lit("R9", 1'b0);
    blk[1] = 1'b0; tick("R9"); lit("R9", 1'b1);
    setup(2'b10, 0, 0, 1, 0, 2'b01, 0);
    a = 1'b1; tick("R9"); lit("R9", 1'b1);

    // R10 asynchronous terms
    setup(2'b00, 0, 0, 0, 0, 2'b00, 0);
    setb = 1'b1; tick("R10"); lit("R10", 1'b1);
    rst = 1'b1; tick("R10"); lit("R10", 1'b0);
    a = 1'b1; active_edge("R10"); lit("R10", 1'b0);
    rst = 1'b0; tick("R10"); lit("R10", 1'b1);
    setb = 1'b0; tick("R10");

    // sweep of every configuration with single-bit random stimulus
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < 128; c++) begin
        setup(2'(k), c[0], c[1], c[2], c[3], c[5:4], c[6]);
        for (int n = 0; n < 28; n++) begin
          case ($urandom_range(0, 11))
            0, 1, 2, 3: begin if (upt) pt = ~pt; else blk[sel] = ~blk[sel]; end
            4:          blk[$urandom_range(0, 3)] = ~blk[$urandom_range(0, 3)];
            5:          pt = ~pt;
            6, 7:       a = ~a;
            8, 9:       b = ~b;
            10:         rst = ~rst;
            default:    setb = ~setb;
          endcase
          tick("sweep R2 R3 R4 R5 R6 R7 R8 R9 R10");
        end
      end

    $display("== %0d vectors applied, %0d miscompares ==", total, fails);
    $finish;
  end
endmodule